// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register file of a PC-style parallel printer port running in compatibility mode. A host reaches it over a plain register bus made of an address, a write strobe, a read strobe, a write byte and a registered read byte. Inside sit a byte latch for outgoing data, a byte latch for incoming data, a status byte and a control byte.

The block has no pin timing. It models the printer side of the handshake instead. When a control write raises the strobe bit while the init and select lines are both asserted, the latched outgoing byte leaves on a valid/byte stream. Busy and acknowledge then step through a fixed sequence, and each status read advances that sequence by one step. An interrupt-pending flag is set by a strobe-low control write, provided interrupts were already enabled, and a status read clears it. The flag drives a level interrupt output.

Top module: `prn_port_regs`

## Requirements
- R1: Only the low three address bits select a register, so upper bits are ignored. Offset 0 is data, offset 1 is status and offset 2 is control. A read at offsets 3 to 7 returns 0xFF. Writes to offsets 1 and 3 to 7 change no state.
- R2: After reset, a data read returns 0xFF, status reads 0xD9 and control reads 0xCC. The irq and out_valid outputs are 0.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. Control bits are: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 init, 1 autofeed, 0 strobe.
- R4: rdata is updated one cycle after a read strobe and holds its value at all other times. When wr_en and rd_en are high in the same cycle, only the write takes effect.
- R5: A data read returns the incoming latch (0xFF since reset) when control bit 5 is 1, and the outgoing latch, last written at offset 0, when it is 0.
- R6: A control write with init (bit 2) = 0 sets status bits 7 (busy, active-low), 6 (acknowledge), 4 (online) and 3 (error, active-low).
- R7: A control write with init = 1, select = 1 and strobe = 1 clears status bit 7. If the stored strobe bit was 0 before that write, out_valid is high for exactly the next cycle and out_byte carries the outgoing latch.
- R8: A control write with init = 1, select = 1 and strobe = 0 sets interrupt-pending when the stored control byte already had interrupt enable set. irq equals interrupt-pending.
- R9: A status read returns the status as it was before the read, and it clears interrupt-pending.
- R10: If status bit 7 is 0 and the stored strobe is 0, a status read updates the status after returning it. A set acknowledge bit is cleared. A clear acknowledge bit is set again, and busy is set with it.
- R11: A control write with init = 1 and select = 0 leaves status and interrupt-pending unchanged and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address, taken modulo 8 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_byte | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt, equal to interrupt-pending |

## Verification
The bench builds the block with an 8-bit address and the default hold-last-byte output. The wider address lets it show that address 0x0A reaches the control register, which exercises the modulo-8 aliasing. Its reference model tracks the busy and acknowledge sequence through whole strobe cycles. That includes the double strobe-high write that must not emit, and the select-low writes that must leave everything untouched. A write and a read in the same cycle are also driven, to show that the read is dropped.

// File: rtl/prn_pkg.sv
package prn_pkg;
   localparam int BYTE_W  = 8;
   localparam int OFS_W   = 3;
   localparam int N_OFS   = 1 << OFS_W;

   // register offsets
   localparam int OFS_DATA = 0;
   localparam int OFS_STAT = 1;
   localparam int OFS_CTRL = 2;

   // status bit positions
   localparam int ST_BUSY_N = 7;
   localparam int ST_ACK    = 6;
   localparam int ST_PAPER  = 5;
   localparam int ST_ONLINE = 4;
   localparam int ST_ERR_N  = 3;
   localparam int ST_TMO    = 0;

   // control bit positions
   localparam int CT_DIR_IN = 5;
   localparam int CT_IEN    = 4;
   localparam int CT_SEL    = 3;
   localparam int CT_INIT   = 2;
   localparam int CT_AFD    = 1;
   localparam int CT_STB    = 0;

   localparam logic [BYTE_W-1:0] CT_FORCE_ONES = 8'hC0;
   localparam logic [BYTE_W-1:0] ST_INIT_SET   =
      (8'h1 << ST_BUSY_N) | (8'h1 << ST_ACK) | (8'h1 << ST_ONLINE) | (8'h1 << ST_ERR_N);
   localparam logic [BYTE_W-1:0] UNMAPPED_VAL  = 8'hFF;

   localparam logic [BYTE_W-1:0] DEF_RST_DATA = 8'hFF;
   localparam logic [BYTE_W-1:0] DEF_RST_STAT = 8'hD9;
   localparam logic [BYTE_W-1:0] DEF_RST_CTRL = 8'hCC;
endpackage

// File: rtl/prn_addr_dec.sv
module prn_addr_dec
   import prn_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [N_OFS-1:0]  wr_sel,
   output logic [N_OFS-1:0]  rd_sel
);
   logic [OFS_W-1:0] ofs;

   initial begin
      if (ADDR_W < OFS_W) $error("prn_addr_dec: ADDR_W must be at least %0d", OFS_W);
   end

   generate
      if (ADDR_W == OFS_W) begin : g_exact
         assign ofs = addr;
      end else begin : g_trim
         logic addr_unused;
         assign ofs         = addr[OFS_W-1:0];
         assign addr_unused = ^addr[ADDR_W-1:OFS_W];
      end
   endgenerate

   // a read that shares its cycle with a write is dropped
   always_comb begin
      wr_sel = '0;
      rd_sel = '0;
      if (wr_en)       wr_sel[ofs] = 1'b1;
      else if (rd_en)  rd_sel[ofs] = 1'b1;
   end
endmodule

// File: rtl/prn_status_reg.sv
module prn_status_reg
   import prn_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RST_STAT = DEF_RST_STAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] ctl_new,
   input  logic [BYTE_W-1:0] ctl_q,
   input  logic              rd_stat,
   output logic [BYTE_W-1:0] stat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= RST_STAT;
      end else if (wr_ctrl) begin
         if (!ctl_new[CT_INIT]) begin
            stat_q <= stat_q | ST_INIT_SET;
         end else if (ctl_new[CT_SEL] && ctl_new[CT_STB]) begin
            stat_q[ST_BUSY_N] <= 1'b0;
         end
      end else if (rd_stat && !stat_q[ST_BUSY_N] && !ctl_q[CT_STB]) begin
         if (stat_q[ST_ACK]) begin
            stat_q[ST_ACK] <= 1'b0;
         end else begin
            stat_q[ST_ACK]    <= 1'b1;
            stat_q[ST_BUSY_N] <= 1'b1;
         end
      end
   end

   // R6: an init-low control write raises the four handshake bits
   p_init_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !ctl_new[CT_INIT]) |=> ((stat_q & ST_INIT_SET) == ST_INIT_SET));

   // R7: a strobe-high write with init and select drops busy
   p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && ctl_new[CT_INIT] && ctl_new[CT_SEL] && ctl_new[CT_STB]) |=> !stat_q[ST_BUSY_N]);

   // R11: select low with init high leaves status alone
   p_sel_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && ctl_new[CT_INIT] && !ctl_new[CT_SEL]) |=> $stable(stat_q));
endmodule

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
   import prn_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RST_CTRL  = DEF_RST_CTRL,
   parameter bit                ZERO_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              rd_stat,
   input  logic [BYTE_W-1:0] wlatch,
   output logic [BYTE_W-1:0] ctl_new,
   output logic [BYTE_W-1:0] ctl_q,
   output logic              pend,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte
);
   logic              fire;
   logic              arm;
   logic [BYTE_W-1:0] byte_q;

   initial begin
      if ((RST_CTRL & CT_FORCE_ONES) != CT_FORCE_ONES)
         $error("prn_ctrl_reg: RST_CTRL must have its forced bits set");
   end

   assign ctl_new = wdata | CT_FORCE_ONES;
   assign fire = wr_ctrl && ctl_new[CT_INIT] && ctl_new[CT_SEL] && ctl_new[CT_STB] && !ctl_q[CT_STB];
   assign arm  = wr_ctrl && ctl_new[CT_INIT] && ctl_new[CT_SEL] && !ctl_new[CT_STB] && ctl_q[CT_IEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= RST_CTRL;
         pend      <= 1'b0;
         out_valid <= 1'b0;
         byte_q    <= '0;
      end else begin
         out_valid <= fire;
         if (fire)    byte_q <= wlatch;
         if (wr_ctrl) ctl_q  <= ctl_new;
         if (arm)          pend <= 1'b1;
         else if (rd_stat) pend <= 1'b0;
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign out_byte = out_valid ? byte_q : '0;
      end else begin : g_hold
         assign out_byte = byte_q;
      end
   endgenerate

   // R9: status read drops the pending flag
   p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> !pend);

   // R7: valid is a single-cycle pulse caused by a control write
   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   p_pulse_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(wr_ctrl));

   // R11: select low never touches pending
   p_pend_sel_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && ctl_new[CT_INIT] && !ctl_new[CT_SEL]) |=> ($stable(pend) && !out_valid));
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
   import prn_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [BYTE_W-1:0] RST_DATA  = DEF_RST_DATA,
   parameter logic [BYTE_W-1:0] RST_STAT  = DEF_RST_STAT,
   parameter logic [BYTE_W-1:0] RST_CTRL  = DEF_RST_CTRL,
   parameter bit                ZERO_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic              irq
);
   logic [N_OFS-1:0]  wr_sel;
   logic [N_OFS-1:0]  rd_sel;
   logic [BYTE_W-1:0] wlatch;
   logic [BYTE_W-1:0] rlatch;
   logic [BYTE_W-1:0] ctl_new;
   logic [BYTE_W-1:0] ctl_q;
   logic [BYTE_W-1:0] stat_q;
   logic              pend;
   logic [BYTE_W-1:0] rd_mux;

   prn_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
      .addr   (addr),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .wr_sel (wr_sel),
      .rd_sel (rd_sel)
   );

   prn_ctrl_reg #(.RST_CTRL(RST_CTRL), .ZERO_IDLE(ZERO_IDLE)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_sel[OFS_CTRL]),
      .wdata     (wdata),
      .rd_stat   (rd_sel[OFS_STAT]),
      .wlatch    (wlatch),
      .ctl_new   (ctl_new),
      .ctl_q     (ctl_q),
      .pend      (pend),
      .out_valid (out_valid),
      .out_byte  (out_byte)
   );

   prn_status_reg #(.RST_STAT(RST_STAT)) i_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_sel[OFS_CTRL]),
      .ctl_new (ctl_new),
      .ctl_q   (ctl_q),
      .rd_stat (rd_sel[OFS_STAT]),
      .stat_q  (stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wlatch <= RST_DATA;
         rlatch <= RST_DATA;
      end else begin
         if (wr_sel[OFS_DATA]) wlatch <= wdata;
      end
   end

   always_comb begin
      rd_mux = UNMAPPED_VAL;
      if (rd_sel[OFS_DATA])      rd_mux = ctl_q[CT_DIR_IN] ? rlatch : wlatch;
      else if (rd_sel[OFS_STAT]) rd_mux = stat_q;
      else if (rd_sel[OFS_CTRL]) rd_mux = ctl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (|rd_sel) rdata <= rd_mux;
   end

   assign irq = pend;

   // R1: unmapped offsets read as all ones
   p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && (addr[OFS_W-1:0] > 3'd2)) |=> (rdata == UNMAPPED_VAL));

   // R3: control reads always show the forced top bits
   p_ctrl_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && (addr[OFS_W-1:0] == 3'd2)) |=> (rdata[7:6] == 2'b11));

   // R4: read data only moves after a lone read strobe
   p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

// File: tb/test_prn_port_regs.sv
module test_prn_port_regs;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prn_port_regs i_prn_port_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wdata     (wdata),
      .rdata     (rdata),
      .out_valid (out_valid),
      .out_byte  (out_byte),
      .irq       (irq)
   );

   // behavioural reference
   logic [7:0] m_wl, m_rl, m_st, m_ct, m_rd, m_ob;
   logic       m_pend, m_ov;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wl = 8'hFF; m_rl = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC;
         m_rd = 8'h00; m_ob = 8'h00; m_pend = 1'b0; m_ov = 1'b0;
      end else begin
         int o;
         logic [7:0] nv;
         o = addr % 8;
         m_ov = 1'b0;
         if (wr_en) begin
            if (o == 0) m_wl = wdata;
            else if (o == 2) begin
               nv = wdata | 8'hC0;
               if (nv[2] == 1'b0) m_st = m_st | 8'hD8;
               else if (nv[3]) begin
                  if (nv[0]) begin
                     m_st = m_st & 8'h7F;
                     if (m_ct[0] == 1'b0) begin m_ov = 1'b1; m_ob = m_wl; end
                  end else if (m_ct[4]) m_pend = 1'b1;
               end
               m_ct = nv;
            end
         end else if (rd_en) begin
            if (o == 0) m_rd = m_ct[5] ? m_rl : m_wl;
            else if (o == 2) m_rd = m_ct;
            else if (o == 1) begin
               m_rd = m_st;
               m_pend = 1'b0;
               if (!m_st[7] && !m_ct[0]) begin
                  if (m_st[6]) m_st = m_st & 8'hBF;
                  else         m_st = m_st | 8'hC0;
               end
            end else m_rd = 8'hFF;
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // model comparison every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 model rdata", rdata, m_rd);
         chk("R8 model irq", {7'd0, irq}, {7'd0, m_pend});
         chk("R7 model out_valid", {7'd0, out_valid}, {7'd0, m_ov});
         chk("R7 model out_byte", out_byte, m_ob);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(tag, rdata, exp);
   endtask

   task automatic emit_chk(input logic [7:0] d, input bit exp_v, input logic [7:0] exp_b, input string tag);
      wr(8'h02, d);
      chk(tag, {7'd0, out_valid}, {7'd0, exp_v});
      if (exp_v) chk(tag, out_byte, exp_b);
      @(negedge clk);
      chk(tag, {7'd0, out_valid}, 8'h00);
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 irq", {7'd0, irq}, 8'h00);
      chk("R2 out_valid", {7'd0, out_valid}, 8'h00);
      rd(8'h02, 8'hCC, "R2 control");
      rd(8'h01, 8'hD9, "R2 status");
      rd(8'h00, 8'hFF, "R2 data");
      // R5 data direction
      wr(8'h00, 8'h5A);
      rd(8'h00, 8'h5A, "R5 out latch");
      wr(8'h02, 8'h20);
      rd(8'h00, 8'hFF, "R5 in latch");
      rd(8'h02, 8'hE0, "R3 forced ones");
      // R8 pending needs previously stored enable
      wr(8'h02, 8'h1C);
      chk("R8 no enable yet", {7'd0, irq}, 8'h00);
      wr(8'h02, 8'h1C);
      chk("R8 irq set", {7'd0, irq}, 8'h01);
      rd(8'h01, 8'hD9, "R9 status value");
      chk("R9 irq cleared", {7'd0, irq}, 8'h00);
      // R7 strobe edge
      emit_chk(8'h1D, 1'b1, 8'h5A, "R7 emit");
      emit_chk(8'h1D, 1'b0, 8'h00, "R7 no second emit");
      rd(8'h01, 8'h59, "R7 busy low");
      wr(8'h02, 8'h1C);
      chk("R8 irq again", {7'd0, irq}, 8'h01);
      // R10 ack/busy sequence
      rd(8'h01, 8'h59, "R10 step1");
      rd(8'h01, 8'h19, "R10 step2");
      rd(8'h01, 8'hD9, "R10 step3");
      // R1 decode
      rd(8'h05, 8'hFF, "R1 unmapped");
      rd(8'h0A, 8'hDC, "R1 alias");
      wr(8'h01, 8'h00);
      rd(8'h01, 8'hD9, "R1 status write ignored");
      wr(8'h03, 8'h00);
      rd(8'h02, 8'hDC, "R1 offset3 write ignored");
      // R11 select low
      emit_chk(8'h15, 1'b0, 8'h00, "R11 no emit");
      wr(8'h02, 8'h14);
      chk("R11 no pending", {7'd0, irq}, 8'h00);
      rd(8'h01, 8'hD9, "R11 status kept");
      // R6 init low restores handshake bits
      wr(8'h00, 8'hA5);
      wr(8'h02, 8'h1C);
      emit_chk(8'h1D, 1'b1, 8'hA5, "R7 emit second byte");
      wr(8'h02, 8'h18);
      rd(8'h01, 8'hD9, "R6 init low");
      // R4 simultaneous read and write
      @(negedge clk);
      addr = 8'h02; wdata = 8'h00; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R4 read dropped", rdata, 8'hD9);
      rd(8'h02, 8'hC0, "R4 write kept");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule